// File: doc/BRIEF.md
# Configurable Slave SPI Shift Converter

This block is a slave serial port that is set up either as a receiver that gathers a 16-bit parallel word from a serial stream, or as a transmitter that sends out an 8-bit or 16-bit parallel word bit by bit. The choice is made by a static mode input. One external data pin serves both directions. A direction setting decides whether that pin is driven. A two-bit path select decides whether the pin carries this block's shift output or a serial stream that a neighbouring converter supplies.

The serial clock and the active-low chip select come from internal routing. Both are sampled by the system clock `clk`, so every serial clock edge and select edge is seen as a one-cycle event. Bits travel most significant first. Incoming data is taken on the rising serial clock edge, and outgoing data moves on the falling edge. When a transmit transfer starts, the word to send is built from three 8-bit sources: two counter/state values, A and B, and one converter result. In 16-bit transmit, A fills the upper byte and B the lower byte. In 8-bit transmit, a select bit picks A or the converter result.

Top module: `spi_shift_conv`

## Requirements
- R1: After reset `par_out` is 0, `pad_oe` is 0, and the shift output on `pad_out` (path code 1x) is 0.
- R2: In receive mode (`cfg_xmit`=0), with `spi_cs_n` low, each rising `spi_clk` edge shifts `pad_in` into the word. The first bit received ends up in `par_out[15]` and the sixteenth in `par_out[0]`.
- R3: `par_out` changes only in the system cycle that takes in the sixteenth bit of a transfer. After fifteen bits it still shows the previous word, and while `spi_cs_n` is high it is held.
- R4: If `spi_cs_n` rises before sixteen bits have arrived, the partial word is discarded and `par_out` keeps its previous value.
- R5: Bits clocked in after the sixteenth, before `spi_cs_n` rises, are ignored: `par_out` keeps the completed word and the bit counter stays at 16.
- R6: In 16-bit transmit (`cfg_xmit`=1, `cfg_len16`=1), the falling edge of `spi_cs_n` loads {`src_a`, `src_b`}. Bit 15 is on the shift output before the first rising `spi_clk` edge, and the next bit follows on each falling `spi_clk` edge.
- R7: In 8-bit transmit (`cfg_len16`=0), the word sent is `src_a` when `cfg_src_conv`=0 and `conv_data` when `cfg_src_conv`=1, most significant bit first.
- R8: While `spi_cs_n` is high, the shift register holds its value, so the shift output on `pad_out` does not change.
- R9: `pad_oe` is 1 only when `cfg_dir_out`=1 and `spi_cs_n` was sampled low at the previous `clk` edge. Otherwise it is 0.
- R10: Path code 00 or 01 on `cfg_path` puts `conv_sdo` on `pad_out`. Codes 10 and 11 put the shift register's top bit on `pad_out`.
- R11: In transmit mode `par_out` never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial signals |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_clk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| cfg_xmit | input | 1 | 0 = receive into `par_out`, 1 = transmit |
| cfg_len16 | input | 1 | Transmit length: 1 = 16 bits, 0 = 8 bits |
| cfg_src_conv | input | 1 | 8-bit transmit source: 0 = `src_a`, 1 = `conv_data` |
| cfg_dir_out | input | 1 | Pin direction: 1 = pin may be driven |
| cfg_path | input | 2 | Pin driver: 0x = `conv_sdo`, 1x = shift output |
| src_a | input | 8 | Counter/state value A (upper byte in 16-bit transmit) |
| src_b | input | 8 | Counter/state value B (lower byte in 16-bit transmit) |
| conv_data | input | 8 | Converter parallel result |
| conv_sdo | input | 1 | Converter serial output |
| pad_in | input | 1 | Data pin input |
| pad_out | output | 1 | Data pin output value |
| pad_oe | output | 1 | Data pin output enable |
| par_out | output | 16 | Received word: [15:8] upper consumer byte, [7:0] lower |

## Verification
The bound checker enforces four rules on every cycle. The pin is not enabled while the select is idle. The shift output stays frozen while the select is high. The bit counter never passes sixteen. The parallel word changes only right after a rising serial clock edge in receive mode, and never in transmit mode. Several behaviours can only be shown by the bench's scenarios: the bit order and byte placement of received and transmitted words, the choice between `src_a` and `conv_data`, discarding a partial word, ignoring bits after the sixteenth, and the pin multiplexing, because each depends on actual data values.

// File: rtl/spi_conv_pkg.sv
`timescale 1ns/1ps
package spi_conv_pkg;
    typedef enum logic [1:0] {
        PATH_CONV_0  = 2'b00,
        PATH_CONV_1  = 2'b01,
        PATH_SHIFT_0 = 2'b10,
        PATH_SHIFT_1 = 2'b11
    } path_e;

    function automatic logic path_is_shift(input logic [1:0] code);
        return (code == PATH_SHIFT_0) || (code == PATH_SHIFT_1);
    endfunction
endpackage

// File: rtl/spi_edge_detect.sv
`timescale 1ns/1ps
module spi_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_idle_q
);
    typedef struct packed {
        logic sclk;
        logic cs_n;
    } edge_t;

    edge_t edge_d, edge_q;

    always_comb begin
        edge_d      = edge_q;
        edge_d.sclk = sclk;
        edge_d.cs_n = cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q.sclk <= 1'b0;
            edge_q.cs_n <= 1'b1;
        end else begin
            edge_q <= edge_d;
        end
    end

    assign sclk_rise = sclk & ~edge_q.sclk;
    assign sclk_fall = ~sclk & edge_q.sclk;
    assign cs_fall   = ~cs_n & edge_q.cs_n;
    assign cs_idle_q = edge_q.cs_n;
endmodule

// File: rtl/spi_load_mux.sv
`timescale 1ns/1ps
module spi_load_mux #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              len16,
    input  logic              use_conv,
    input  logic [BYTE_W-1:0] src_a,
    input  logic [BYTE_W-1:0] src_b,
    input  logic [BYTE_W-1:0] conv_data,
    output logic [WORD_W-1:0] load_word
);
    logic [BYTE_W-1:0] short_byte;

    always_comb begin
        short_byte = use_conv ? conv_data : src_a;
        if (len16) begin
            load_word = {src_a, src_b};
        end else begin
            load_word = {short_byte, {BYTE_W{1'b0}}};
        end
    end
endmodule

// File: rtl/spi_pad_mux.sv
`timescale 1ns/1ps
module spi_pad_mux
    import spi_conv_pkg::*;
(
    input  logic       dir_out,
    input  logic [1:0] path,
    input  logic       cs_idle_q,
    input  logic       shift_bit,
    input  logic       conv_sdo,
    output logic       pad_out,
    output logic       pad_oe
);
    always_comb begin
        pad_out = path_is_shift(path) ? shift_bit : conv_sdo;
        pad_oe  = dir_out & ~cs_idle_q;
    end
endmodule

// File: rtl/spi_shift_conv.sv
`timescale 1ns/1ps
module spi_shift_conv #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_clk,
    input  logic              spi_cs_n,
    input  logic              cfg_xmit,
    input  logic              cfg_len16,
    input  logic              cfg_src_conv,
    input  logic              cfg_dir_out,
    input  logic [1:0]        cfg_path,
    input  logic [BYTE_W-1:0] src_a,
    input  logic [BYTE_W-1:0] src_b,
    input  logic [BYTE_W-1:0] conv_data,
    input  logic              conv_sdo,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oe,
    output logic [WORD_W-1:0] par_out
);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] par;
    } core_t;

    core_t core_d, core_q;

    logic              sclk_rise, sclk_fall, cs_fall, cs_idle_q;
    logic [WORD_W-1:0] load_word;
    logic [CNT_W-1:0]  tx_limit;
    logic [CNT_W-1:0]  bit_cnt;

    spi_edge_detect u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_clk),
        .cs_n      (spi_cs_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_idle_q (cs_idle_q)
    );

    spi_load_mux #(.BYTE_W(BYTE_W)) u_load (
        .len16     (cfg_len16),
        .use_conv  (cfg_src_conv),
        .src_a     (src_a),
        .src_b     (src_b),
        .conv_data (conv_data),
        .load_word (load_word)
    );

    spi_pad_mux u_pad (
        .dir_out   (cfg_dir_out),
        .path      (cfg_path),
        .cs_idle_q (cs_idle_q),
        .shift_bit (core_q.shreg[WORD_W-1]),
        .conv_sdo  (conv_sdo),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    assign tx_limit = cfg_len16 ? FULL_CNT : SHORT_CNT;

    always_comb begin
        core_d = core_q;
        if (cs_fall) begin
            // start of transfer: clear count, load word when transmitting
            core_d.cnt = '0;
            if (cfg_xmit) begin
                core_d.shreg = load_word;
            end
        end else if (!spi_cs_n) begin
            if (!cfg_xmit) begin
                if (sclk_rise && (core_q.cnt < FULL_CNT)) begin
                    core_d.shreg = {core_q.shreg[WORD_W-2:0], pad_in};
                    core_d.cnt   = core_q.cnt + 1'b1;
                    if (core_q.cnt == LAST_CNT) begin
                        core_d.par = {core_q.shreg[WORD_W-2:0], pad_in};
                    end
                end
            end else begin
                if (sclk_rise && (core_q.cnt < tx_limit)) begin
                    core_d.cnt = core_q.cnt + 1'b1;
                end
                // next bit moves up once the master has sampled a bit
                if (sclk_fall && (core_q.cnt != '0)) begin
                    core_d.shreg = {core_q.shreg[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign par_out = core_q.par;
    assign bit_cnt = core_q.cnt;
endmodule

// File: rtl/spi_shift_conv_chk.sv
`timescale 1ns/1ps
module spi_shift_conv_chk #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_clk,
    input logic              spi_cs_n,
    input logic              cfg_xmit,
    input logic [1:0]        cfg_path,
    input logic              pad_out,
    input logic              pad_oe,
    input logic [WORD_W-1:0] par_out,
    input logic [CNT_W-1:0]  bit_cnt
);
    // R9: pin stays undriven while select is idle
    p_oe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n && $past(spi_cs_n) |-> !pad_oe);

    // R8: shift output frozen while select is idle
    p_shift_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n && $past(spi_cs_n) && cfg_path[1] && $stable(cfg_path)
        |-> $stable(pad_out));

    // R3: word held while select is idle
    p_par_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |=> $stable(par_out));

    // R11: word never moves in transmit mode
    p_par_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_xmit |=> $stable(par_out));

    // R2: word moves only after a rising serial edge in receive mode
    p_par_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(par_out) |-> $past(spi_clk) && !$past(spi_cs_n) && !$past(cfg_xmit));

    // R5: counter saturates at a full word
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(WORD_W));
endmodule

bind spi_shift_conv spi_shift_conv_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_clk  (spi_clk),
    .spi_cs_n (spi_cs_n),
    .cfg_xmit (cfg_xmit),
    .cfg_path (cfg_path),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .par_out  (par_out),
    .bit_cnt  (bit_cnt)
);

// File: tb/sim_spi_shift_conv.sv
`timescale 1ns/1ps
module sim_spi_shift_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_clk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        cfg_xmit = 1'b0;
    logic        cfg_len16 = 1'b1;
    logic        cfg_src_conv = 1'b0;
    logic        cfg_dir_out = 1'b0;
    logic [1:0]  cfg_path = 2'b10;
    logic [7:0]  src_a = 8'h00;
    logic [7:0]  src_b = 8'h00;
    logic [7:0]  conv_data = 8'h00;
    logic        conv_sdo = 1'b0;
    logic        pad_in = 1'b0;
    logic        pad_out;
    logic        pad_oe;
    logic [15:0] par_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    spi_shift_conv u0 (
        .clk(clk), .rst_n(rst_n), .spi_clk(spi_clk), .spi_cs_n(spi_cs_n),
        .cfg_xmit(cfg_xmit), .cfg_len16(cfg_len16), .cfg_src_conv(cfg_src_conv),
        .cfg_dir_out(cfg_dir_out), .cfg_path(cfg_path), .src_a(src_a),
        .src_b(src_b), .conv_data(conv_data), .conv_sdo(conv_sdo),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .par_out(par_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_low();
        spi_cs_n = 1'b0;
        step(4);
    endtask

    task automatic cs_high();
        spi_cs_n = 1'b1;
        step(4);
    endtask

    task automatic rx_bits(input logic [15:0] w, input int first, input int count);
        for (int i = first; i < first + count; i++) begin
            pad_in = w[15-i];
            step(2);
            spi_clk = 1'b1;
            step(3);
            spi_clk = 1'b0;
            step(2);
        end
    endtask

    task automatic tx_run(input logic [15:0] w, input int nbits, input string tag);
        cs_low();
        for (int i = 0; i < nbits; i++) begin
            chk(tag, {31'd0, pad_out}, {31'd0, w[15-i]});
            spi_clk = 1'b1;
            step(3);
            spi_clk = 1'b0;
            step(3);
        end
    endtask

    task automatic t_reset();
        chk("R1 par_out", {16'd0, par_out}, 32'd0);
        chk("R1 pad_oe", {31'd0, pad_oe}, 32'd0);
        chk("R1 shift out", {31'd0, pad_out}, 32'd0);
    endtask

    task automatic t_rx_basic();
        cfg_xmit = 1'b0;
        cs_low();
        rx_bits(16'hA5C3, 0, 15);
        chk("R3 after 15 bits", {16'd0, par_out}, 32'd0);
        rx_bits(16'hA5C3, 15, 1);
        chk("R2 word A5C3", {16'd0, par_out}, 32'hA5C3);
        cs_high();
        chk("R3 held idle", {16'd0, par_out}, 32'hA5C3);
        cs_low();
        rx_bits(16'h8001, 0, 16);
        cs_high();
        chk("R2 word 8001", {16'd0, par_out}, 32'h8001);
    endtask

    task automatic t_rx_partial();
        cs_low();
        rx_bits(16'h1234, 0, 16);
        cs_high();
        cs_low();
        rx_bits(16'hFFFF, 0, 7);
        cs_high();
        chk("R4 partial dropped", {16'd0, par_out}, 32'h1234);
        cs_low();
        rx_bits(16'h5E6F, 0, 16);
        cs_high();
        chk("R4 next full word", {16'd0, par_out}, 32'h5E6F);
    endtask

    task automatic t_rx_extra();
        cs_low();
        rx_bits(16'hBEEF, 0, 16);
        rx_bits(16'h0000, 0, 4);
        chk("R5 extra bits ignored", {16'd0, par_out}, 32'hBEEF);
        cs_high();
        chk("R5 after release", {16'd0, par_out}, 32'hBEEF);
    endtask

    task automatic t_tx16();
        cfg_xmit = 1'b1; cfg_len16 = 1'b1; cfg_dir_out = 1'b1; cfg_path = 2'b10;
        src_a = 8'h9C; src_b = 8'h36;
        step(2);
        tx_run(16'h9C36, 16, "R6 tx16 bit");
        chk("R9 oe active", {31'd0, pad_oe}, 32'd1);
        chk("R11 par unchanged", {16'd0, par_out}, 32'hBEEF);
        cs_high();
        chk("R9 oe idle", {31'd0, pad_oe}, 32'd0);
    endtask

    task automatic t_tx8();
        cfg_len16 = 1'b0; cfg_src_conv = 1'b0;
        src_a = 8'hB4; conv_data = 8'h4B;
        step(2);
        tx_run(16'hB400, 8, "R7 tx8 src_a bit");
        cs_high();
        cfg_src_conv = 1'b1;
        step(2);
        tx_run(16'h4B00, 8, "R7 tx8 conv bit");
        cs_high();
    endtask

    task automatic t_hold();
        cfg_len16 = 1'b1; src_a = 8'hC0; src_b = 8'h00;
        step(2);
        tx_run(16'hC000, 1, "R6 first bit");
        // one rise done; after the fall the second bit (1) is out
        chk("R6 second bit", {31'd0, pad_out}, 32'd1);
        cs_high();
        spi_clk = 1'b1; step(3); spi_clk = 1'b0; step(3);
        chk("R8 held while idle", {31'd0, pad_out}, 32'd1);
    endtask

    task automatic t_oe_dir();
        cfg_dir_out = 1'b0;
        cs_low();
        chk("R9 oe dir in", {31'd0, pad_oe}, 32'd0);
        cs_high();
        cfg_dir_out = 1'b1;
    endtask

    task automatic t_path();
        src_a = 8'h00; src_b = 8'h00; cfg_len16 = 1'b1;
        cs_low(); cs_high();
        cfg_path = 2'b00; conv_sdo = 1'b1; step(1);
        chk("R10 path 00", {31'd0, pad_out}, 32'd1);
        cfg_path = 2'b01; conv_sdo = 1'b0; step(1);
        chk("R10 path 01", {31'd0, pad_out}, 32'd0);
        conv_sdo = 1'b1; step(1);
        chk("R10 path 01 high", {31'd0, pad_out}, 32'd1);
        cfg_path = 2'b11; step(1);
        chk("R10 path 11", {31'd0, pad_out}, 32'd0);
        cfg_path = 2'b10; step(1);
        chk("R10 path 10", {31'd0, pad_out}, 32'd0);
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_rx_basic();
        t_rx_partial();
        t_rx_extra();
        t_tx16();
        t_tx8();
        t_hold();
        t_oe_dir();
        t_path();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule